// File: doc/BRIEF.md
# Buffered Serial Transmitter with Clear-to-Send Gating

This block sends asynchronous serial frames on a single output line. Software-side logic writes a data word into a one-entry holding register. When the shift stage is idle, or finishing its last stop bit, the word moves into the shift stage. The holding register is then free again, so the next word can be written while the current frame is on the line. Each frame has a low start bit, then 8 or 9 data bits least significant first, then an optional parity bit, then one or two high stop bits.

The bit rate comes from a count-source enable input and a divider value n. Each bit lasts 16(n+1) enabled cycles. An optional clear-to-send input holds back the start of a new frame while it is high, but it never cuts a frame short. A transmit-enable input works the same way: clearing it lets the current frame finish and then stops. A sticky interrupt request can fire either when the holding register empties or when all transmission has completed. It stays set until it is acknowledged.

Top module: `sertx_top`

## Requirements
- R1: After reset, `txd` is 1, `buf_empty` is 1, `shift_empty` is 1 and `irq` is 0.
- R2: A frame is a 0 start bit, then data bits starting with bit 0. There are 8 bits, or 9 when `cfg_nine_bit`=1, and then `wr_data[8]` is sent last. A parity bit follows when `cfg_par_en`=1, then the stop bits at 1.
- R3: Every bit lasts exactly 16(`div_n`+1) cycles in which `src_en` is 1. Cycles with `src_en`=0 do not advance the bit timing.
- R4: With `cfg_par_odd`=0 the parity bit makes the count of ones over the sent data bits plus parity even. With `cfg_par_odd`=1 it makes that count odd.
- R5: `cfg_two_stop`=1 sends two stop bits, otherwise one. `shift_empty` rises exactly frame-length × bit-period cycles after the start bit begins.
- R6: A write clears `buf_empty`. The word moves to the shift stage, and `buf_empty` returns to 1, as soon as the shift stage is free. A word that is waiting starts right after the previous stop bit, with no idle gap.
- R7: A write while `buf_empty`=0 replaces the waiting word. Only the last word written is sent.
- R8: With `cfg_fc_en`=1, no frame starts while `cts_in`=1. A frame already under way still completes. The waiting word starts once `cts_in` returns to 0.
- R9: With `cfg_fc_en`=0, `cts_in` has no effect on transmission.
- R10: While `cfg_tx_en`=0 no frame starts and `txd` stays 1. Clearing it during a frame lets that frame finish.
- R11: With `cfg_irq_sel`=0, `irq` is set when a word moves from the holding register into the shift stage.
- R12: With `cfg_irq_sel`=1, `irq` is set only when a frame ends with no word waiting. It is not set between back-to-back frames.
- R13: Once set, `irq` stays 1 until `irq_ack` is 1 for a cycle. A new set event in the same cycle wins over the acknowledge.
- R14: Whenever `shift_empty` is 1, `txd` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| src_en | input | 1 | Count-source enable, one bit-timing step per high cycle |
| div_n | input | DIV_W | Divider value n |
| cfg_tx_en | input | 1 | Transmit enable |
| cfg_nine_bit | input | 1 | 1 = 9 data bits, 0 = 8 |
| cfg_par_en | input | 1 | Parity bit present |
| cfg_par_odd | input | 1 | 1 = odd parity, 0 = even |
| cfg_two_stop | input | 1 | 1 = two stop bits |
| cfg_fc_en | input | 1 | Clear-to-send gating enable |
| cfg_irq_sel | input | 1 | 0 = interrupt on buffer empty, 1 = on transmission complete |
| cts_in | input | 1 | Clear-to-send, high holds off the next frame |
| wr_en | input | 1 | Write strobe for the holding register |
| wr_data | input | DATA_W | Word to send |
| irq_ack | input | 1 | Clears the interrupt request |
| txd | output | 1 | Serial data out, idle high |
| buf_empty | output | 1 | Holding register is empty |
| shift_empty | output | 1 | Shift stage is idle |
| irq | output | 1 | Sticky interrupt request |

## Verification
The hardest situation to reach is a word that is already waiting at the moment a stop bit ends, while clear-to-send or transmit-enable changes part way through the running frame. The bench reaches it with two parallel threads. One decodes the line at bit midpoints. The other writes a second word as soon as `buf_empty` returns high, then toggles `cts_in` or `cfg_tx_en` a fixed number of bit periods into the first frame. The bench then checks that the first frame completes and that the second is held back until the gate reopens. The same overlap, with the interrupt select at 1, shows that no completion request appears between back-to-back frames.

// File: rtl/sertx_pkg.sv
// Package: shared state encoding for the serial transmitter.
// Assumes: used by all sertx_* modules.
package sertx_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_DATA,
        ST_PAR,
        ST_STOP
    } tx_state_e;

endpackage

// File: rtl/sertx_baud.sv
// Module: sertx_baud
// Produces one tick per bit period of 16(n+1) count-source enables.
// Assumes: the counter is held at zero while run is low, so a bit period
// starts exactly on the cycle after a frame is loaded.
module sertx_baud #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             src_en,
    input  logic [DIV_W-1:0] div_n,
    output logic             tick
);
    localparam int CNT_W = DIV_W + 4;

    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] limit;

    // Last count value of a bit: 16*n + 15.
    assign limit = {div_n, 4'hF};
    assign tick  = run && src_en && (cnt == limit);

    // Count enabled source cycles within the current bit.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            cnt <= '0;
        end else if (src_en) begin
            cnt <= (cnt == limit) ? '0 : cnt + 1'b1;
        end
    end
endmodule

// File: rtl/sertx_hold.sv
// Module: sertx_hold
// One-entry holding register in front of the shift stage.
// Assumes: a write in the same cycle as a take refills the entry (the
// taken word is the older one); a write to a full entry overwrites it.
module sertx_hold #(
    parameter int DATA_W = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              take,
    output logic [DATA_W-1:0] data,
    output logic              full
);
    // Track occupancy; writes win over a take.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            full <= 1'b0;
        end else if (wr_en) begin
            full <= 1'b1;
        end else if (take) begin
            full <= 1'b0;
        end
    end

    // Capture written data.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data <= '0;
        end else if (wr_en) begin
            data <= wr_data;
        end
    end
endmodule

// File: rtl/sertx_shift.sv
// Module: sertx_shift
// Frame sequencer and shift register: start, data (LSB first), optional
// parity, one or two stop bits. Frame options are latched at load so a
// change in the middle of a frame only affects the next frame.
// Assumes: DATA_W-1 base data bits, plus a top bit sent only in the
// extended mode; load has priority over tick.
module sertx_shift
    import sertx_pkg::*;
#(
    parameter int DATA_W = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              load,
    input  logic [DATA_W-1:0] load_data,
    input  logic              nine,
    input  logic              par_en,
    input  logic              par_odd,
    input  logic              two_stop,
    output logic              txd,
    output logic              idle,
    output logic              frame_done
);
    localparam int IDX_W = $clog2(DATA_W + 1);

    tx_state_e         state;
    logic [DATA_W-1:0] sreg;
    logic [DATA_W-1:0] masked;
    logic [IDX_W-1:0]  bit_idx;
    logic [IDX_W-1:0]  last_idx;
    logic              par_bit;
    logic              extra_stop;
    logic              f_par_en;

    // Drop the top data bit unless the extended width is selected.
    for (genvar i = 0; i < DATA_W; i++) begin : g_mask
        if (i < DATA_W - 1) begin : g_base
            assign masked[i] = load_data[i];
        end else begin : g_top
            assign masked[i] = load_data[i] & nine;
        end
    end

    assign idle       = (state == ST_IDLE);
    assign frame_done = tick && (state == ST_STOP) && !extra_stop;

    // Sequence the frame one bit per tick.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state      <= ST_IDLE;
            sreg       <= '0;
            bit_idx    <= '0;
            last_idx   <= '0;
            par_bit    <= 1'b0;
            extra_stop <= 1'b0;
            f_par_en   <= 1'b0;
        end else if (load) begin
            state      <= ST_START;
            sreg       <= masked;
            bit_idx    <= '0;
            last_idx   <= nine ? IDX_W'(DATA_W - 1) : IDX_W'(DATA_W - 2);
            par_bit    <= (^masked) ^ par_odd;
            extra_stop <= two_stop;
            f_par_en   <= par_en;
        end else if (tick) begin
            case (state)
                ST_START: state <= ST_DATA;
                ST_DATA: begin
                    sreg    <= sreg >> 1;
                    bit_idx <= bit_idx + 1'b1;
                    if (bit_idx == last_idx) begin
                        state <= f_par_en ? ST_PAR : ST_STOP;
                    end
                end
                ST_PAR:  state <= ST_STOP;
                ST_STOP: begin
                    if (extra_stop) begin
                        extra_stop <= 1'b0;
                    end else begin
                        state <= ST_IDLE;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // Drive the line level for the current bit.
    always_comb begin
        case (state)
            ST_START: txd = 1'b0;
            ST_DATA:  txd = sreg[0];
            ST_PAR:   txd = par_bit;
            default:  txd = 1'b1;
        endcase
    end
endmodule

// File: rtl/sertx_irq.sv
// Module: sertx_irq
// Sticky interrupt request with a selectable trigger.
// Assumes: set wins over acknowledge in the same cycle.
module sertx_irq (
    input  logic clk,
    input  logic rst_n,
    input  logic sel,
    input  logic taken,
    input  logic frame_done,
    input  logic buf_full,
    input  logic ack,
    output logic irq
);
    logic set_ev;

    // Select the trigger: word taken, or frame ended with nothing waiting.
    assign set_ev = sel ? (frame_done && !taken && !buf_full) : taken;

    // Hold the request until acknowledged.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq <= 1'b0;
        end else if (set_ev) begin
            irq <= 1'b1;
        end else if (ack) begin
            irq <= 1'b0;
        end
    end
endmodule

// File: rtl/sertx_top.sv
// Module: sertx_top
// Buffered serial transmitter: holding register, bit timer, frame shifter
// and interrupt flag. A new frame starts only when enabled, a word is
// waiting and clear-to-send permits, either from idle or at the end of the
// last stop bit.
// Assumes: configuration inputs are quasi-static; cts_in is synchronous.
module sertx_top
    import sertx_pkg::*;
#(
    parameter int DIV_W  = 8,
    parameter int DATA_W = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              src_en,
    input  logic [DIV_W-1:0]  div_n,
    input  logic              cfg_tx_en,
    input  logic              cfg_nine_bit,
    input  logic              cfg_par_en,
    input  logic              cfg_par_odd,
    input  logic              cfg_two_stop,
    input  logic              cfg_fc_en,
    input  logic              cfg_irq_sel,
    input  logic              cts_in,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              irq_ack,
    output logic              txd,
    output logic              buf_empty,
    output logic              shift_empty,
    output logic              irq
);
    logic              hold_full;
    logic [DATA_W-1:0] hold_data;
    logic              tick;
    logic              sh_idle;
    logic              frame_done;
    logic              may_start;
    logic              take;

    // Start permission and hand-over from the holding register.
    assign may_start = cfg_tx_en && hold_full && (!cfg_fc_en || !cts_in);
    assign take      = may_start && (sh_idle || frame_done);

    assign buf_empty   = !hold_full;
    assign shift_empty = sh_idle;

    sertx_hold #(.DATA_W(DATA_W)) u_hold (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .take    (take),
        .data    (hold_data),
        .full    (hold_full)
    );

    sertx_baud #(.DIV_W(DIV_W)) u_baud (
        .clk    (clk),
        .rst_n  (rst_n),
        .run    (!sh_idle),
        .src_en (src_en),
        .div_n  (div_n),
        .tick   (tick)
    );

    sertx_shift #(.DATA_W(DATA_W)) u_shift (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick       (tick),
        .load       (take),
        .load_data  (hold_data),
        .nine       (cfg_nine_bit),
        .par_en     (cfg_par_en),
        .par_odd    (cfg_par_odd),
        .two_stop   (cfg_two_stop),
        .txd        (txd),
        .idle       (sh_idle),
        .frame_done (frame_done)
    );

    sertx_irq u_irq (
        .clk        (clk),
        .rst_n      (rst_n),
        .sel        (cfg_irq_sel),
        .taken      (take),
        .frame_done (frame_done),
        .buf_full   (hold_full),
        .ack        (irq_ack),
        .irq        (irq)
    );
endmodule

// File: rtl/sertx_checker.sv
// Module: sertx_checker
// Port-level temporal properties of sertx_top, bound to every instance.
module sertx_checker (
    input logic clk,
    input logic rst_n,
    input logic wr_en,
    input logic cfg_tx_en,
    input logic cfg_fc_en,
    input logic cts_in,
    input logic irq_ack,
    input logic txd,
    input logic buf_empty,
    input logic shift_empty,
    input logic irq
);
    assert_idle_line_R14: assert property (@(posedge clk) disable iff (!rst_n)
        shift_empty |-> txd);

    assert_cts_holds_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_fc_en && cts_in && shift_empty) |=> shift_empty);

    assert_tx_off_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_tx_en && shift_empty) |=> shift_empty);

    assert_irq_sticky_R13: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !irq_ack) |=> irq);

    assert_fill_by_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(buf_empty) |-> $past(wr_en));

    assert_start_needs_word_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(shift_empty) |-> $past(!buf_empty));
endmodule

bind sertx_top sertx_checker u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_en       (wr_en),
    .cfg_tx_en   (cfg_tx_en),
    .cfg_fc_en   (cfg_fc_en),
    .cts_in      (cts_in),
    .irq_ack     (irq_ack),
    .txd         (txd),
    .buf_empty   (buf_empty),
    .shift_empty (shift_empty),
    .irq         (irq)
);

// File: tb/sertx_top_tb.sv
// Bench for sertx_top: sweeps frame options and divider values, and
// exercises the flow-control, enable and interrupt corner cases.
module sertx_top_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       src_en = 1'b1;
    logic       src_half = 1'b0;
    logic [7:0] div_n = '0;
    logic       cfg_tx_en = 1'b1;
    logic       cfg_nine_bit = 1'b0;
    logic       cfg_par_en = 1'b0;
    logic       cfg_par_odd = 1'b0;
    logic       cfg_two_stop = 1'b0;
    logic       cfg_fc_en = 1'b0;
    logic       cfg_irq_sel = 1'b0;
    logic       cts_in = 1'b0;
    logic       wr_en = 1'b0;
    logic [8:0] wr_data = '0;
    logic       irq_ack = 1'b0;
    logic       txd, buf_empty, shift_empty, irq;

    int     n_chk = 0;
    int     n_err = 0;
    bit     done = 0;
    longint cyc = 0;

    always #4 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;
    always @(negedge clk) src_en <= src_half ? ~src_en : 1'b1;

    sertx_top u_dut (
        .clk(clk), .rst_n(rst_n), .src_en(src_en), .div_n(div_n),
        .cfg_tx_en(cfg_tx_en), .cfg_nine_bit(cfg_nine_bit),
        .cfg_par_en(cfg_par_en), .cfg_par_odd(cfg_par_odd),
        .cfg_two_stop(cfg_two_stop), .cfg_fc_en(cfg_fc_en),
        .cfg_irq_sel(cfg_irq_sel), .cts_in(cts_in), .wr_en(wr_en),
        .wr_data(wr_data), .irq_ack(irq_ack), .txd(txd),
        .buf_empty(buf_empty), .shift_empty(shift_empty), .irq(irq)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    function automatic int frame_len(input logic nine, par, two);
        return 1 + (nine ? 9 : 8) + (par ? 1 : 0) + (two ? 2 : 1);
    endfunction

    function automatic logic [12:0] exp_frame(input logic [8:0] d,
                                              input logic nine, par, odd);
        logic [12:0] f = '1;
        logic [8:0]  m = nine ? d : {1'b0, d[7:0]};
        int          k = 1;
        f[0] = 1'b0;
        for (int i = 0; i < (nine ? 9 : 8); i++) begin
            f[k] = d[i];
            k++;
        end
        if (par) f[k] = (^m) ^ odd;
        return f;
    endfunction

    task automatic write_word(input logic [8:0] d);
        @(negedge clk);
        wr_en = 1'b1;
        wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic wait_buf_empty();
        do @(negedge clk); while (buf_empty !== 1'b1);
    endtask

    task automatic ack_pulse();
        @(negedge clk);
        irq_ack = 1'b1;
        @(negedge clk);
        irq_ack = 1'b0;
    endtask

    // Decode one frame at bit midpoints using the current frame options.
    task automatic rx_frame(input int P, input logic [8:0] d, input bit want_len,
                            input string tag, output longint t_fall);
        logic [12:0] got = '1;
        int B = frame_len(cfg_nine_bit, cfg_par_en, cfg_two_stop);
        int elapsed;
        do @(negedge clk); while (txd !== 1'b0);
        t_fall = cyc;
        repeat (P / 2) @(negedge clk);
        got[0] = txd;
        elapsed = P / 2;
        for (int k = 1; k < B; k++) begin
            repeat (P) @(negedge clk);
            got[k] = txd;
            elapsed += P;
        end
        chk({tag, " frame bits"}, int'(got),
            int'(exp_frame(d, cfg_nine_bit, cfg_par_en, cfg_par_odd)));
        if (want_len) begin
            while (shift_empty !== 1'b1 && elapsed < (B + 4) * P) begin
                @(negedge clk);
                elapsed++;
            end
            chk({tag, " frame length"}, elapsed, B * P);
        end
    endtask

    // Count cycles with a start bit on the line over a window.
    task automatic quiet_window(input int len, input string tag);
        int lows = 0;
        repeat (len) begin
            @(negedge clk);
            if (txd !== 1'b1) lows++;
        end
        chk({tag, " line stays high"}, lows, 0);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog: actual running expected finished");
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    end

    initial begin : main
        longint t1, t2;
        int P;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        chk("R1 txd", int'(txd), 1);
        chk("R1 buf_empty", int'(buf_empty), 1);
        chk("R1 shift_empty", int'(shift_empty), 1);
        chk("R1 irq", int'(irq), 0);

        // R2 R4 R5 R3: sweep all frame options at two divider values
        for (int n = 0; n < 2; n++) begin
            for (int c = 0; c < 16; c++) begin
                logic [8:0] d = 9'(9'h1A5 ^ (c * 37 + n * 91));
                div_n = 8'(n);
                cfg_nine_bit = c[0];
                cfg_par_en = c[1];
                cfg_par_odd = c[2];
                cfg_two_stop = c[3];
                P = 16 * (n + 1);
                fork
                    rx_frame(P, d, 1'b1, "R2/R3/R4/R5 sweep", t1);
                    write_word(d);
                join
                repeat (3) @(negedge clk);
            end
        end

        // R3: source enable at half rate doubles the bit period
        cfg_nine_bit = 0; cfg_par_en = 1; cfg_par_odd = 0; cfg_two_stop = 0;
        div_n = 8'd0;
        src_half = 1'b1;
        fork
            rx_frame(32, 9'h0C3, 1'b0, "R3 half-rate source", t1);
            write_word(9'h0C3);
        join
        repeat (40) @(negedge clk);
        src_half = 1'b0;
        repeat (4) @(negedge clk);

        // R6: back-to-back frames with no idle gap
        cfg_par_en = 0;
        P = 16;
        fork
            rx_frame(P, 9'h05A, 1'b0, "R6 first", t1);
            begin
                write_word(9'h05A);
                wait_buf_empty();
                chk("R6 shifter busy after hand-over", int'(shift_empty), 0);
                write_word(9'h0E1);
                chk("R6 buffer full while shifting", int'(buf_empty), 0);
            end
        join
        rx_frame(P, 9'h0E1, 1'b1, "R6 second", t2);
        chk("R6 start-to-start spacing", int'(t2 - t1), 10 * P);

        // R7 R10: overwrite while disabled, nothing sent until enabled
        cfg_tx_en = 1'b0;
        write_word(9'h011);
        write_word(9'h0F0);
        quiet_window(100, "R10 disabled");
        chk("R10 shifter idle while disabled", int'(shift_empty), 1);
        fork
            rx_frame(P, 9'h0F0, 1'b1, "R7 overwritten word", t1);
            begin @(negedge clk); cfg_tx_en = 1'b1; end
        join

        // R8: clear-to-send high holds off a waiting word
        cfg_fc_en = 1'b1;
        cts_in = 1'b1;
        write_word(9'h03C);
        quiet_window(200, "R8 cts high");
        chk("R8 word still waiting", int'(buf_empty), 0);
        fork
            rx_frame(P, 9'h03C, 1'b1, "R8 after cts low", t1);
            begin @(negedge clk); cts_in = 1'b0; end
        join

        // R8: cts rises mid-frame, frame completes, next is held
        fork
            rx_frame(P, 9'h0A7, 1'b0, "R8 frame in progress", t1);
            begin
                write_word(9'h0A7);
                wait_buf_empty();
                write_word(9'h019);
                repeat (3 * P) @(negedge clk);
                cts_in = 1'b1;
            end
        join
        quiet_window(300, "R8 held after stop");
        chk("R8 held word waiting", int'(buf_empty), 0);
        fork
            rx_frame(P, 9'h019, 1'b1, "R8 released", t1);
            begin @(negedge clk); cts_in = 1'b0; end
        join

        // R9: flow control off ignores cts
        cfg_fc_en = 1'b0;
        cts_in = 1'b1;
        fork
            rx_frame(P, 9'h066, 1'b1, "R9 cts ignored", t1);
            write_word(9'h066);
        join
        cts_in = 1'b0;

        // R10: disable mid-frame, frame finishes, waiting word held
        fork
            rx_frame(P, 9'h0B4, 1'b0, "R10 finishing frame", t1);
            begin
                write_word(9'h0B4);
                wait_buf_empty();
                write_word(9'h04B);
                repeat (2 * P) @(negedge clk);
                cfg_tx_en = 1'b0;
            end
        join
        quiet_window(300, "R10 after disable");
        chk("R10 word waiting", int'(buf_empty), 0);
        fork
            rx_frame(P, 9'h04B, 1'b1, "R10 re-enabled", t1);
            begin @(negedge clk); cfg_tx_en = 1'b1; end
        join

        // R11 R13: interrupt on hand-over, sticky until acknowledged
        cfg_irq_sel = 1'b0;
        ack_pulse();
        chk("R13 cleared by ack", int'(irq), 0);
        fork
            rx_frame(P, 9'h0D2, 1'b1, "R11 frame", t1);
            begin
                write_word(9'h0D2);
                repeat (3) @(negedge clk);
                chk("R11 irq on hand-over", int'(irq), 1);
                chk("R11 frame under way", int'(shift_empty), 0);
            end
        join
        chk("R13 irq still held", int'(irq), 1);
        ack_pulse();
        chk("R13 irq after ack", int'(irq), 0);

        // R12: interrupt only at completion with nothing waiting
        cfg_irq_sel = 1'b1;
        fork
            rx_frame(P, 9'h08E, 1'b0, "R12 first", t1);
            begin
                write_word(9'h08E);
                wait_buf_empty();
                write_word(9'h071);
                repeat (P) @(negedge clk);
                chk("R12 no irq mid-frame", int'(irq), 0);
            end
        join
        rx_frame(P, 9'h071, 1'b0, "R12 second", t2);
        chk("R12 no irq between frames", int'(irq), 0);
        do @(negedge clk); while (shift_empty !== 1'b1);
        chk("R12 irq at completion", int'(irq), 1);
        chk("R14 idle line high", int'(txd), 1);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end
endmodule